// File: doc/BRIEF.md
# Floating-Point Maximum/Minimum Number Unit

This unit takes two 64-bit operand words and returns either the larger or the smaller of them as IEEE 754 binary floating-point values. It follows the 2008 rules for maxNum and minNum. If one operand is a quiet NaN and the other is a number, the number wins. Any signalling NaN still produces a NaN and raises an invalid-operation flag. One select input picks maximum or minimum, and the rest of the datapath is the same for both.

Three element formats are handled: binary16, binary32 and binary64. In scalar mode only the lowest element of each operand word is used, and the result sits in the low bits of the output with zeros above it. In packed mode the word is split into four, two or one lanes, and each lane is compared on its own. Packed mode always applies default-NaN and flush-to-zero. Scalar mode takes those two settings from control inputs. The result and the flag are registered, one clock after the operands are presented.

Top module: `fpMaxMin`

## Requirements
- R1: For two non-NaN operands, maximum returns operand A when A is greater than or equal to B, otherwise B. Minimum returns A when A is less than or equal to B, otherwise B.
- R2: Signed zeros are ordered with +0 above -0. So max(+0,-0) and max(-0,+0) both give +0, and minimum gives -0 in both orders.
- R3: When exactly one operand is a quiet NaN (exponent all ones, top fraction bit 1) and the other is not a NaN, the result is the other operand.
- R4: `invalid` is 1 exactly when at least one operand element is a signalling NaN (exponent all ones, top fraction bit 0, fraction nonzero). In that case the element result is a NaN.
- R5: If an operand is a signalling NaN, or both operands are NaNs, the result depends on default-NaN. With default-NaN on, the result is the default NaN: sign 0, exponent all ones, only the top fraction bit set. With default-NaN off, the result is the NaN operand with its top fraction bit forced to 1, and operand A is used if both operands are NaN.
- R6: With flush-to-zero on, a subnormal operand (exponent 0, fraction nonzero) is replaced by a zero of the same sign, both for the comparison and as the value returned.
- R7: The `fmt` input selects the element format: 0 is binary16, 1 is binary32, 2 is binary64, and 3 also acts as binary64.
- R8: In scalar mode the operand element is taken from bits [15:0], [31:0] or [63:0] of each operand. Higher operand bits are ignored, and the result bits above the element are 0.
- R9: In packed mode, lane k of a W-bit format occupies bits [W*k+W-1:W*k] of operands and result. Lanes are independent, and `invalid` is the OR of the lanes' flags.
- R10: Packed mode behaves as if default-NaN and flush-to-zero were both on, whatever the values of `dnCtl` and `fzCtl`.
- R11: Result and flag appear one clock edge after the operands are presented. While `rstN` is low they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 64 | First operand word |
| opB | input | 64 | Second operand word |
| selMin | input | 1 | 1 selects minimum, 0 maximum |
| fmt | input | 2 | Element format |
| simdMode | input | 1 | 1 selects packed lanes, 0 scalar |
| dnCtl | input | 1 | Default-NaN enable for scalar mode |
| fzCtl | input | 1 | Flush-to-zero enable for scalar mode |
| result | output | 64 | Registered result word |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The block has one register stage, so the result and flag for a set of inputs become visible one rising edge after those inputs are applied. The bench changes inputs on a falling edge, lets exactly one rising edge pass, and compares on the next falling edge, before it drives the next vector. The embedded properties use `$past` of the inputs by one cycle to match that same single stage. They stay inactive until one captured cycle has passed since reset.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int WORD_W   = 64;
  localparam int HALF_E   = 5;
  localparam int HALF_F   = 10;
  localparam int SINGLE_E = 8;
  localparam int SINGLE_F = 23;
  localparam int DOUBLE_E = 11;
  localparam int DOUBLE_F = 52;
  localparam int HALF_W   = 1 + HALF_E + HALF_F;
  localparam int SINGLE_W = 1 + SINGLE_E + SINGLE_F;
  localparam int DOUBLE_W = 1 + DOUBLE_E + DOUBLE_F;
  localparam int N_HALF   = WORD_W / HALF_W;
  localparam int N_SINGLE = WORD_W / SINGLE_W;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_RSVD   = 2'd3
  } fmtE;

  typedef struct packed {
    logic pickMin;
    logic useDn;
    logic useFz;
    logic selHalf;
    logic selSingle;
    logic selDouble;
    logic lanesPacked;
  } ctrlS;
endpackage

// File: rtl/fmmLane.sv
module fmmLane #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         pickMin,
  input  logic         useDn,
  input  logic         useFz,
  output logic [W-1:0] res,
  output logic         sigInvalid
);
  localparam logic [W-1:0] SIGN_BIT  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QUIET_BIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic isNanA, isNanB, sigA, sigB, subA, subB;
  logic [W-1:0] flA, flB, keyA, keyB, nanPick;
  logic aWins;

  assign expA  = a[W-2:FRAC_W];
  assign expB  = b[W-2:FRAC_W];
  assign fracA = a[FRAC_W-1:0];
  assign fracB = b[FRAC_W-1:0];

  assign isNanA = (&expA) && (|fracA);
  assign isNanB = (&expB) && (|fracB);
  assign sigA   = isNanA && !fracA[FRAC_W-1];
  assign sigB   = isNanB && !fracB[FRAC_W-1];
  assign subA   = (~|expA) && (|fracA);
  assign subB   = (~|expB) && (|fracB);

  // subnormal inputs become signed zero when flushing
  assign flA = (useFz && subA) ? (a & SIGN_BIT) : a;
  assign flB = (useFz && subB) ? (b & SIGN_BIT) : b;

  // sign-magnitude to monotonic unsigned key; -0 sorts just below +0
  assign keyA = flA[W-1] ? ~flA : (flA | SIGN_BIT);
  assign keyB = flB[W-1] ? ~flB : (flB | SIGN_BIT);
  assign aWins = pickMin ? (keyA <= keyB) : (keyA >= keyB);

  assign nanPick = isNanA ? (a | QUIET_BIT) : (b | QUIET_BIT);

  always_comb begin
    sigInvalid = sigA || sigB;
    if (sigA || sigB || (isNanA && isNanB)) begin
      res = useDn ? DEF_NAN : nanPick;
    end else if (isNanA) begin
      res = flB;
    end else if (isNanB) begin
      res = flA;
    end else begin
      res = aWins ? flA : flB;
    end
  end
endmodule

// File: rtl/fmmCtrl.sv
module fmmCtrl
  import fmm_pkg::*;
(
  input  logic       selMin,
  input  logic [1:0] fmt,
  input  logic       simdMode,
  input  logic       dnCtl,
  input  logic       fzCtl,
  output ctrlS       strb
);
  always_comb begin
    strb.pickMin     = selMin;
    strb.lanesPacked = simdMode;
    // packed lanes run with the standard fixed controls
    strb.useDn       = simdMode | dnCtl;
    strb.useFz       = simdMode | fzCtl;
    strb.selHalf     = (fmt == FMT_HALF);
    strb.selSingle   = (fmt == FMT_SINGLE);
    strb.selDouble   = (fmt == FMT_DOUBLE) || (fmt == FMT_RSVD);
  end
endmodule

// File: rtl/fmmDatapath.sv
module fmmDatapath
  import fmm_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  ctrlS              strb,
  output logic [WORD_W-1:0] resWord,
  output logic              resInvalid
);
  logic [HALF_W-1:0]   hRes [N_HALF];
  logic [N_HALF-1:0]   hInv;
  logic [SINGLE_W-1:0] sRes [N_SINGLE];
  logic [N_SINGLE-1:0] sInv;
  logic [DOUBLE_W-1:0] dRes;
  logic                dInv;
  logic [WORD_W-1:0]   hPacked, sPacked;

  for (genvar h = 0; h < N_HALF; h++) begin : gHalf
    fmmLane #(.EXP_W(HALF_E), .FRAC_W(HALF_F)) uLane (
      .a(opA[HALF_W*h +: HALF_W]), .b(opB[HALF_W*h +: HALF_W]),
      .pickMin(strb.pickMin), .useDn(strb.useDn), .useFz(strb.useFz),
      .res(hRes[h]), .sigInvalid(hInv[h]));
    assign hPacked[HALF_W*h +: HALF_W] = hRes[h];
  end

  for (genvar s = 0; s < N_SINGLE; s++) begin : gSingle
    fmmLane #(.EXP_W(SINGLE_E), .FRAC_W(SINGLE_F)) uLane (
      .a(opA[SINGLE_W*s +: SINGLE_W]), .b(opB[SINGLE_W*s +: SINGLE_W]),
      .pickMin(strb.pickMin), .useDn(strb.useDn), .useFz(strb.useFz),
      .res(sRes[s]), .sigInvalid(sInv[s]));
    assign sPacked[SINGLE_W*s +: SINGLE_W] = sRes[s];
  end

  fmmLane #(.EXP_W(DOUBLE_E), .FRAC_W(DOUBLE_F)) uDouble (
    .a(opA), .b(opB),
    .pickMin(strb.pickMin), .useDn(strb.useDn), .useFz(strb.useFz),
    .res(dRes), .sigInvalid(dInv));

  always_comb begin
    resWord    = '0;
    resInvalid = 1'b0;
    if (strb.selDouble) begin
      resWord    = dRes;
      resInvalid = dInv;
    end else if (strb.selSingle) begin
      if (strb.lanesPacked) begin
        resWord    = sPacked;
        resInvalid = |sInv;
      end else begin
        resWord[SINGLE_W-1:0] = sRes[0];
        resInvalid            = sInv[0];
      end
    end else if (strb.selHalf) begin
      if (strb.lanesPacked) begin
        resWord    = hPacked;
        resInvalid = |hInv;
      end else begin
        resWord[HALF_W-1:0] = hRes[0];
        resInvalid          = hInv[0];
      end
    end
  end
endmodule

// File: rtl/fpMaxMin.sv
module fpMaxMin
  import fmm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              selMin,
  input  logic [1:0]        fmt,
  input  logic              simdMode,
  input  logic              dnCtl,
  input  logic              fzCtl,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  ctrlS              strb;
  logic [WORD_W-1:0] nextRes;
  logic              nextInv;
  logic              armed;

  fmmCtrl uCtrl (
    .selMin(selMin), .fmt(fmt), .simdMode(simdMode),
    .dnCtl(dnCtl), .fzCtl(fzCtl), .strb(strb));

  fmmDatapath uPath (
    .opA(opA), .opB(opB), .strb(strb),
    .resWord(nextRes), .resInvalid(nextInv));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      invalid <= 1'b0;
      armed   <= 1'b0;
    end else begin
      result  <= nextRes;
      invalid <= nextInv;
      armed   <= 1'b1;
    end
  end

  // R8
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(fmt == 2'd0 && !simdMode) |-> result[63:16] == '0);

  // R4
  inv_gives_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && invalid && $past(fmt == 2'd2 && !simdMode)
    |-> (&result[62:52]) && (|result[51:0]));

  // R5
  nan_out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(fmt == 2'd2) && (&result[62:52]) && (|result[51:0])
    |-> result[51]);

  // R1
  operand_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(fmt == 2'd2 && !simdMode && !fzCtl)
    && !((&result[62:52]) && (|result[51:0]))
    |-> (result == $past(opA)) || (result == $past(opB)));

  // R10
  packed_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(fmt == 2'd2 && simdMode)
    |-> (result[62:52] != '0) || (result[51:0] == '0));
endmodule

// File: tb/tb_fpMaxMin.sv
`timescale 1ns/1ps
module tb_fpMaxMin;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        selMin = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        simdMode = 1'b0, dnCtl = 1'b0, fzCtl = 1'b0;
  logic [63:0] result;
  logic        invalid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpMaxMin dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .selMin(selMin),
    .fmt(fmt), .simdMode(simdMode), .dnCtl(dnCtl), .fzCtl(fzCtl),
    .result(result), .invalid(invalid));

  localparam int NSPEC = 16;

  function automatic logic [63:0] specVal(input int idx, input int e, input int f);
    logic [63:0] sb, eo, one, top, fm;
    sb  = 64'd1 << (e + f);
    fm  = (64'd1 << f) - 64'd1;
    eo  = ((64'd1 << e) - 64'd1) << f;
    one = ((64'd1 << (e - 1)) - 64'd1) << f;
    top = 64'd1 << (f - 1);
    case (idx)
      0:  return 64'd0;
      1:  return sb;
      2:  return 64'd1;
      3:  return sb | fm;
      4:  return one;
      5:  return sb | one;
      6:  return one + (64'd1 << f);
      7:  return eo - (64'd1 << f) + fm;
      8:  return eo;
      9:  return sb | eo;
      10: return eo | top;
      11: return sb | eo | top | 64'd5;
      12: return eo | 64'd1;
      13: return sb | eo | (top >> 1) | 64'd3;
      14: return one | top;
      default: return sb | one | 64'd1;
    endcase
  endfunction

  function automatic logic [63:0] refLane(input logic [63:0] a0, input logic [63:0] b0,
      input int e, input int f, input bit mn, input bit dn, input bit fz, output bit inv);
    logic [63:0] a, b, fm, em, sbit, qb, dnan, ma, mb;
    logic [63:0] ea, eb, fa, fb;
    bit nanA, nanB, snA, snB, aGt;
    a = a0; b = b0;
    fm = (64'd1 << f) - 64'd1;
    em = (64'd1 << e) - 64'd1;
    sbit = 64'd1 << (e + f);
    qb = 64'd1 << (f - 1);
    ea = (a >> f) & em; eb = (b >> f) & em;
    fa = a & fm; fb = b & fm;
    nanA = (ea == em) && (fa != 0);
    nanB = (eb == em) && (fb != 0);
    snA = nanA && ((a & qb) == 0);
    snB = nanB && ((b & qb) == 0);
    if (fz && ea == 0 && fa != 0) a = a & sbit;
    if (fz && eb == 0 && fb != 0) b = b & sbit;
    inv = snA || snB;
    dnan = (em << f) | qb;
    if (inv || (nanA && nanB)) return dn ? dnan : ((nanA ? a : b) | qb);
    if (nanA) return b;
    if (nanB) return a;
    ma = a & (sbit - 64'd1);
    mb = b & (sbit - 64'd1);
    if ((a & sbit) != (b & sbit)) aGt = ((a & sbit) == 0);
    else if ((a & sbit) == 0) aGt = ma > mb;
    else aGt = ma < mb;
    if (!mn) return (aGt || a == b) ? a : b;
    return (!aGt) ? a : b;
  endfunction

  function automatic string classTag(input logic [63:0] a, input logic [63:0] b,
      input int e, input int f, input bit fz);
    logic [63:0] fm, em, qb;
    bit nA, nB;
    fm = (64'd1 << f) - 64'd1; em = (64'd1 << e) - 64'd1; qb = 64'd1 << (f - 1);
    nA = (((a >> f) & em) == em) && ((a & fm) != 0);
    nB = (((b >> f) & em) == em) && ((b & fm) != 0);
    if ((nA && (a & qb) == 0) || (nB && (b & qb) == 0)) return "R4";
    if (nA && nB) return "R5";
    if (nA || nB) return "R3";
    if (fz && ((((a >> f) & em) == 0 && (a & fm) != 0) || (((b >> f) & em) == 0 && (b & fm) != 0)))
      return "R6";
    if ((a & ~(64'd1 << (e + f))) == 0 && (b & ~(64'd1 << (e + f))) == 0) return "R2";
    return "R1";
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: result %h expected %h (fmt %0d simd %0d min %0d dn %0d fz %0d)",
               tag, act, exp, fmt, simdMode, selMin, dnCtl, fzCtl);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: invalid %0b expected %0b", tag, act, exp);
    end
  endtask

  // inputs change at a falling edge; one rising edge registers them; compare at next falling edge
  task automatic applyVec(input logic [63:0] a, input logic [63:0] b, input bit mn,
      input logic [1:0] fm, input bit simd, input bit dn, input bit fz);
    opA = a; opB = b; selMin = mn; fmt = fm; simdMode = simd; dnCtl = dn; fzCtl = fz;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic scalarSweep(input logic [1:0] fm, input int e, input int f, input string fmtTag);
    int w;
    logic [63:0] a, b, exp, junk;
    bit inv;
    w = 1 + e + f;
    for (int i = 0; i < NSPEC; i++)
      for (int j = 0; j < NSPEC; j++)
        for (int m = 0; m < 8; m++) begin
          a = specVal(i, e, f); b = specVal(j, e, f);
          exp = refLane(a, b, e, f, m[0], m[1], m[2], inv);
          junk = (w < 64) ? (64'hA5C3_F00F_1234_5678 << w) : 64'd0;
          applyVec(a | junk, b | ~junk & ~((w < 64) ? ((64'd1 << w) - 1) : '1),
                   m[0], fm, 1'b0, m[1], m[2]);
          check64(classTag(a, b, e, f, m[2]), result, exp);
          check1("R4", invalid, inv);
          if (w < 64) check64("R8", result >> w, 64'd0);
          if (fmtTag.len() != 0) check64(fmtTag, result, exp);
        end
  endtask

  task automatic packedSweep(input logic [1:0] fm, input int e, input int f);
    int w, nl;
    logic [63:0] a, b, exp, la, lb, lr, msk;
    bit inv, linv;
    w = 1 + e + f;
    nl = 64 / w;
    msk = (w < 64) ? ((64'd1 << w) - 1) : '1;
    for (int i = 0; i < NSPEC; i++)
      for (int j = 0; j < NSPEC; j++)
        for (int m = 0; m < 2; m++) begin
          a = '0; b = '0; exp = '0; inv = 1'b0;
          for (int k = 0; k < nl; k++) begin
            la = specVal((i + k) % NSPEC, e, f);
            lb = specVal((j + 3 * k) % NSPEC, e, f);
            lr = refLane(la, lb, e, f, m[0], 1'b1, 1'b1, linv);
            a = a | (la << (w * k));
            b = b | (lb << (w * k));
            exp = exp | ((lr & msk) << (w * k));
            inv = inv | linv;
          end
          // control bits held off to show packed mode overrides them
          applyVec(a, b, m[0], fm, 1'b1, 1'b0, 1'b0);
          check64("R10", result, exp);
          check1("R9", invalid, inv);
        end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check64("R11", result, 64'd0);
    check1("R11", invalid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: one-edge latency
    applyVec(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    check64("R11", result, 64'h4000_0000_0000_0000);
    scalarSweep(2'd0, 5, 10, "");
    scalarSweep(2'd1, 8, 23, "");
    scalarSweep(2'd2, 11, 52, "");
    scalarSweep(2'd3, 11, 52, "R7");
    packedSweep(2'd0, 5, 10);
    packedSweep(2'd1, 8, 23);
    packedSweep(2'd2, 11, 52);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule